// File: doc/BRIEF.md
# Timer Capture/Compare Control Unit

This block is a free-running up-counter with two input-capture channels and two output-compare channels, all reached through a byte-wide register bus. Each capture channel brings its input pin through a synchronizer. It then watches for the chosen edge and stores the counter value at that moment. Each compare channel holds a compare value. When the counter equals that value, the channel sets a flag and, if its pin is enabled, moves the pin to a programmed level. Software can also force a pin to its programmed level at any time.

In pulse mode, the level of channel 2 is the level used for compare pin 1. Capture, compare and overflow flags are cleared by writing ones to them. The three flag groups, each under its own enable, are combined into a single interrupt request.

The bus is a plain synchronous write strobe with a combinational read path. Sixteen-bit values are reached as a low and a high byte.

Top module: `tcc_top`

## Requirements
- R1: After reset the counter reads 0 and advances by one on every clock. It rolls over from 2^CNT_W-1 to 0.
- R2: The rollover sets the overflow flag (status bit 4) on the same clock edge that the counter becomes 0.
- R3: Capture channel 1 uses control bit 2 to pick its edge: 1 selects rising and 0 selects falling. The opposite edge is ignored. On the chosen edge the channel sets status bit 0 and loads capture register 1 (low byte at address 5, high byte at 6). The value loaded is the counter value SYNC_STAGES clocks after the pin change was first sampled.
- R4: Capture channel 2 behaves the same way, with its edge chosen by mode bit 3. It uses status bit 1 and capture register 2 (low byte at 7, high byte at 8).
- R5: When the counter equals compare register x, compare flag x is set one clock later. Compare register 1 is at addresses 9/10 and compare register 2 at 11/12 (low/high); the flags are status bits 2 and 3. If output enable x is set (mode bit 0 for pin 1, bit 1 for pin 2), pin x takes its level at that same edge: control bit 0 for pin 1 and bit 1 for pin 2. A pin whose enable is clear outputs 0.
- R6: Writing the control register with force bit x set copies the written level x to pin x without a match. Force 1 is bit 3 and force 2 is bit 4. This only happens when output enable x is set; otherwise the force is ignored. Force bits read back as 0.
- R7: While mode bit 2 (pulse mode) is set, pin 1 takes the level-2 bit instead of the level-1 bit, both on a match and on a force.
- R8: A status write (address 2) clears every flag whose data bit is 1 and leaves flags written 0 unchanged. A flag event in the same cycle wins over the clear.
- R9: The irq output is high when any of the following holds: capture enable (control bit 5) is set and either capture flag is set; compare enable (bit 6) is set and either compare flag is set; overflow enable (bit 7) is set and the overflow flag is set. Otherwise irq is low.
- R10: Reset clears control, mode and status, sets both compare registers to 0xFFFF and drives both pins low. Control (address 0), mode (1) and the compare registers read back what was written. The counter reads at addresses 3 (low byte) and 4 (high byte).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cap_in | input | 2 | Capture pins, bit 0 is channel 1 |
| cmp_out | output | 2 | Compare pins, bit 0 is channel 1 |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with CNT_W = 10 and SYNC_STAGES = 2. The 10-bit counter rolls over every 1024 clocks, so the overflow flag, its interrupt and the wrap to zero are reached within a short run without any way to preload the counter. The bench keeps its own copy of the counter. With two synchronizer stages, the exact captured value and the exact clock of each compare match can be predicted and checked one edge before and one edge after the event.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    localparam int BUS_W  = 8;
    localparam int ADDR_W = 4;
    localparam int REG_W  = 16;
    localparam int NCH    = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL    = 4'd0,
        A_MODE    = 4'd1,
        A_STAT    = 4'd2,
        A_CNT_LO  = 4'd3,
        A_CNT_HI  = 4'd4,
        A_CAP1_LO = 4'd5,
        A_CAP1_HI = 4'd6,
        A_CAP2_LO = 4'd7,
        A_CAP2_HI = 4'd8,
        A_CMP1_LO = 4'd9,
        A_CMP1_HI = 4'd10,
        A_CMP2_LO = 4'd11,
        A_CMP2_HI = 4'd12
    } reg_addr_e;

    // control byte, MSB first
    typedef struct packed {
        logic ie_ovf;
        logic ie_cmp;
        logic ie_cap;
        logic force2;
        logic force1;
        logic edge1;
        logic lvl2;
        logic lvl1;
    } ctrl_t;

    typedef struct packed {
        logic [3:0] spare;
        logic       edge2;
        logic       pulse;
        logic       oe2;
        logic       oe1;
    } mode_t;

    typedef struct packed {
        logic [2:0] spare;
        logic       ovf;
        logic       cmp2;
        logic       cmp1;
        logic       cap2;
        logic       cap1;
    } stat_t;

    function automatic logic [BUS_W-1:0] pick_byte(input logic [REG_W-1:0] v,
                                                   input logic hi);
        return hi ? v[REG_W-1:BUS_W] : v[BUS_W-1:0];
    endfunction

endpackage

// File: rtl/tcc_counter.sv
module tcc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) cnt_o <= '0;
        else     cnt_o <= cnt_o + 1'b1;
    end

    // high while the next edge rolls the counter to zero
    assign wrap_o = (cnt_o == TOP);
endmodule

// File: rtl/tcc_capture_ch.sv
module tcc_capture_ch
    import tcc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_i,
    input  logic             rise_sel_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [REG_W-1:0] value_o,
    output logic             hit_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   cur;
    logic [REG_W-1:0]       cnt_wide;

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= (sync_q << 1) | SYNC_STAGES'(pin_i);
            last_q <= cur;
        end
    end

    always_comb begin
        if (rise_sel_i) hit_o = cur & ~last_q;
        else            hit_o = ~cur & last_q;
    end

    always_comb begin
        cnt_wide = '0;
        cnt_wide[CNT_W-1:0] = cnt_i;
    end

    always_ff @(posedge clk) begin
        if (rst)        value_o <= '0;
        else if (hit_o) value_o <= cnt_wide;
    end
endmodule

// File: rtl/tcc_compare_ch.sv
module tcc_compare_ch
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic             oe_i,
    input  logic             match_lvl_i,
    input  logic             force_i,
    input  logic             force_lvl_i,
    output logic [REG_W-1:0] value_o,
    output logic             hit_o,
    output logic             pin_o
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            value_o <= '1;
        end else begin
            if (wr_lo_i) value_o[BUS_W-1:0]     <= wdata_i;
            if (wr_hi_i) value_o[REG_W-1:BUS_W] <= wdata_i;
        end
    end

    assign hit_o = (cnt_i == value_o[CNT_W-1:0]);

    // a force in the same cycle as a match takes precedence
    always_ff @(posedge clk) begin
        if (rst)                  pin_q <= 1'b0;
        else if (oe_i && force_i) pin_q <= force_lvl_i;
        else if (oe_i && hit_o)   pin_q <= match_lvl_i;
    end

    assign pin_o = oe_i & pin_q;
endmodule

// File: rtl/tcc_top.sv
module tcc_top
    import tcc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NCH-1:0]    cap_in,
    output logic [NCH-1:0]    cmp_out,
    output logic              irq
);
    localparam int NREG = 2 ** ADDR_W;

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    logic [REG_W-1:0] cnt_wide;
    logic [NREG-1:0]  wr_sel;
    ctrl_t            ctrl_q;
    ctrl_t            wr_ctrl;
    mode_t            mode_q;
    stat_t            stat_q;
    stat_t            stat_d;

    logic [REG_W-1:0] cap_val [NCH];
    logic [NCH-1:0]   cap_hit;
    logic [NCH-1:0]   cap_rise;
    logic [REG_W-1:0] cmp_val [NCH];
    logic [NCH-1:0]   cmp_hit;
    logic [NCH-1:0]   cmp_wr_lo;
    logic [NCH-1:0]   cmp_wr_hi;
    logic [NCH-1:0]   cmp_oe;
    logic [NCH-1:0]   cmp_mlvl;
    logic [NCH-1:0]   cmp_force;
    logic [NCH-1:0]   cmp_flvl;

    tcc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt_q),
        .wrap_o (wrap)
    );

    always_comb begin
        cnt_wide = '0;
        cnt_wide[CNT_W-1:0] = cnt_q;
    end

    always_comb begin
        wr_sel = '0;
        if (bus_wr) wr_sel[bus_addr] = 1'b1;
    end

    assign wr_ctrl = ctrl_t'(bus_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mode_q <= '0;
        end else begin
            if (wr_sel[A_CTRL]) begin
                ctrl_q        <= wr_ctrl;
                ctrl_q.force1 <= 1'b0;
                ctrl_q.force2 <= 1'b0;
            end
            if (wr_sel[A_MODE]) begin
                mode_q       <= mode_t'(bus_wdata);
                mode_q.spare <= '0;
            end
        end
    end

    // per-channel hookup; pulse mode moves level 2 onto pin 1
    always_comb begin
        cap_rise  = {mode_q.edge2, ctrl_q.edge1};
        cmp_wr_lo = {wr_sel[A_CMP2_LO], wr_sel[A_CMP1_LO]};
        cmp_wr_hi = {wr_sel[A_CMP2_HI], wr_sel[A_CMP1_HI]};
        cmp_oe    = {mode_q.oe2, mode_q.oe1};
        cmp_force = {wr_sel[A_CTRL] & wr_ctrl.force2,
                     wr_sel[A_CTRL] & wr_ctrl.force1};
        cmp_mlvl  = {ctrl_q.lvl2,  mode_q.pulse ? ctrl_q.lvl2  : ctrl_q.lvl1};
        cmp_flvl  = {wr_ctrl.lvl2, mode_q.pulse ? wr_ctrl.lvl2 : wr_ctrl.lvl1};
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tcc_capture_ch #(
            .CNT_W       (CNT_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_cap (
            .clk        (clk),
            .rst        (rst),
            .pin_i      (cap_in[i]),
            .rise_sel_i (cap_rise[i]),
            .cnt_i      (cnt_q),
            .value_o    (cap_val[i]),
            .hit_o      (cap_hit[i])
        );

        tcc_compare_ch #(.CNT_W(CNT_W)) u_cmp (
            .clk         (clk),
            .rst         (rst),
            .cnt_i       (cnt_q),
            .wr_lo_i     (cmp_wr_lo[i]),
            .wr_hi_i     (cmp_wr_hi[i]),
            .wdata_i     (bus_wdata),
            .oe_i        (cmp_oe[i]),
            .match_lvl_i (cmp_mlvl[i]),
            .force_i     (cmp_force[i]),
            .force_lvl_i (cmp_flvl[i]),
            .value_o     (cmp_val[i]),
            .hit_o       (cmp_hit[i]),
            .pin_o       (cmp_out[i])
        );
    end

    // write-one-to-clear, new events win over the clear
    always_comb begin
        stat_d = stat_q;
        if (wr_sel[A_STAT]) stat_d = stat_q & ~stat_t'(bus_wdata);
        stat_d.cap1  = stat_d.cap1 | cap_hit[0];
        stat_d.cap2  = stat_d.cap2 | cap_hit[1];
        stat_d.cmp1  = stat_d.cmp1 | cmp_hit[0];
        stat_d.cmp2  = stat_d.cmp2 | cmp_hit[1];
        stat_d.ovf   = stat_d.ovf  | wrap;
        stat_d.spare = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    assign irq = (ctrl_q.ie_cap & (stat_q.cap1 | stat_q.cap2))
               | (ctrl_q.ie_cmp & (stat_q.cmp1 | stat_q.cmp2))
               | (ctrl_q.ie_ovf & stat_q.ovf);

    always_comb begin
        case (bus_addr)
            A_CTRL:    bus_rdata = ctrl_q;
            A_MODE:    bus_rdata = mode_q;
            A_STAT:    bus_rdata = stat_q;
            A_CNT_LO:  bus_rdata = pick_byte(cnt_wide, 1'b0);
            A_CNT_HI:  bus_rdata = pick_byte(cnt_wide, 1'b1);
            A_CAP1_LO: bus_rdata = pick_byte(cap_val[0], 1'b0);
            A_CAP1_HI: bus_rdata = pick_byte(cap_val[0], 1'b1);
            A_CAP2_LO: bus_rdata = pick_byte(cap_val[1], 1'b0);
            A_CAP2_HI: bus_rdata = pick_byte(cap_val[1], 1'b1);
            A_CMP1_LO: bus_rdata = pick_byte(cmp_val[0], 1'b0);
            A_CMP1_HI: bus_rdata = pick_byte(cmp_val[0], 1'b1);
            A_CMP2_LO: bus_rdata = pick_byte(cmp_val[1], 1'b0);
            A_CMP2_HI: bus_rdata = pick_byte(cmp_val[1], 1'b1);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic [15:0]      cmp1,
    input logic [15:0]      cmp2,
    input logic [7:0]       stat,
    input logic [7:0]       ctrl,
    input logic             irq
);
    localparam logic [CNT_W-1:0] TOP = '1;

    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_wrap_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt == TOP) |=> stat[4]);

    assert_match1_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt == cmp1[CNT_W-1:0]) |=> stat[2]);

    assert_match2_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt == cmp2[CNT_W-1:0]) |=> stat[3]);

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl[7:5] == 3'b000) |-> !irq);

    assert_irq_ovf_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl[7] && stat[4]) |-> irq);
endmodule

bind tcc_top tcc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .cnt  (cnt_q),
    .cmp1 (cmp_val[0]),
    .cmp2 (cmp_val[1]),
    .stat (stat_q),
    .ctrl (ctrl_q),
    .irq  (irq)
);

// File: tb/tb_tcc_top.sv
module tb_tcc_top;
    localparam int CNT_W = 10;
    localparam int SYNC  = 2;
    localparam logic [CNT_W-1:0] TOP = '1;

    localparam logic [3:0] CTRL = 4'd0, MODE = 4'd1, STAT = 4'd2,
        CNTL = 4'd3, CNTH = 4'd4, CP1L = 4'd5, CP1H = 4'd6, CP2L = 4'd7,
        CP2H = 4'd8, CM1L = 4'd9, CM1H = 4'd10, CM2L = 4'd11, CM2H = 4'd12;

    // {write, addr, data, read mask}
    localparam int NV = 16;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, CM1H, 8'h01, 8'h00}, {1'b1, CM1L, 8'h23, 8'h00},
        {1'b0, CM1H, 8'h01, 8'hFF}, {1'b0, CM1L, 8'h23, 8'hFF},
        {1'b1, CM2H, 8'h02, 8'h00}, {1'b1, CM2L, 8'h5A, 8'h00},
        {1'b0, CM2H, 8'h02, 8'hFF}, {1'b0, CM2L, 8'h5A, 8'hFF},
        {1'b1, MODE, 8'h0C, 8'h00}, {1'b0, MODE, 8'h0C, 8'hFF},
        {1'b1, MODE, 8'h00, 8'h00}, {1'b0, MODE, 8'h00, 8'hFF},
        {1'b1, CTRL, 8'h1F, 8'h00}, {1'b0, CTRL, 8'h07, 8'hFF},
        {1'b1, CTRL, 8'h00, 8'h00}, {1'b0, CTRL, 8'h00, 8'hFF}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] cap_in = '0;
    logic [1:0] cmp_out;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [CNT_W-1:0] exp_cnt;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) exp_cnt <= '0;
        else     exp_cnt <= exp_cnt + 1'b1;
    end

    tcc_top #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_in    (cap_in),
        .cmp_out   (cmp_out),
        .irq       (irq)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rd(lo, l);
        rd(lo + 4'd1, h);
        v = {h, l};
    endtask

    task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
        wr(lo, v[7:0]);
        wr(lo + 4'd1, v[15:8]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0]       d;
        logic [15:0]      v;
        logic [CNT_W-1:0] c;
        logic [CNT_W-1:0] tgt;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        rd(CTRL, d); check("R10 ctrl reset", d, 0);
        rd(MODE, d); check("R10 mode reset", d, 0);
        rd(STAT, d); check("R10 stat reset", d, 0);
        rd16(CM1L, v); check("R10 cmp1 reset", v, 16'hFFFF);
        rd16(CM2L, v); check("R10 cmp2 reset", v, 16'hFFFF);
        check("R10 pins reset", cmp_out, 0);
        check("R10 irq reset", irq, 0);

        // R1 counter
        rd16(CNTL, v); check("R1 count at release", v, 16'(exp_cnt));
        repeat (7) @(negedge clk);
        rd16(CNTL, v); check("R1 count running", v, 16'(exp_cnt));

        // R10 table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) wr(VEC[i][19:16], VEC[i][15:8]);
            else begin
                rd(VEC[i][19:16], d);
                check("R10 table", d & VEC[i][7:0], VEC[i][15:8] & VEC[i][7:0]);
            end
        end
        check("R6 force with enables clear", cmp_out, 0);

        // R3 rising capture on channel 1
        wr(CTRL, 8'h04);
        wr(STAT, 8'h1F);
        c = exp_cnt; cap_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        rd16(CP1L, v); check("R3 rising capture value", v, 16'(c + SYNC));
        rd(STAT, d); check("R3 capture flag", d[0], 1);
        wr(STAT, 8'h01);
        cap_in[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd(STAT, d); check("R3 falling ignored flag", d[0], 0);
        rd16(CP1L, v); check("R3 falling ignored value", v, 16'(c + SYNC));
        // falling selected
        wr(CTRL, 8'h00);
        cap_in[0] = 1'b1;
        repeat (5) @(negedge clk);
        rd(STAT, d); check("R3 rising ignored flag", d[0], 0);
        c = exp_cnt; cap_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        rd16(CP1L, v); check("R3 falling capture value", v, 16'(c + SYNC));
        check("R9 capture irq off", irq, 0);
        wr(CTRL, 8'h20);
        check("R9 capture irq", irq, 1);

        // R4 channel 2 rising
        wr(MODE, 8'h08);
        c = exp_cnt; cap_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        rd16(CP2L, v); check("R4 capture2 value", v, 16'(c + SYNC));
        rd(STAT, d); check("R4 capture2 flag", d[1], 1);
        wr(STAT, 8'h1F);
        check("R8 clear drops irq", irq, 0);

        // R5 compare 1 with pin enabled
        wr(MODE, 8'h03);
        wr(CTRL, 8'h01);
        tgt = exp_cnt + 10'd40;
        wr16(CM1L, 16'(tgt));
        wr(STAT, 8'h1F);
        while (exp_cnt != tgt) @(negedge clk);
        rd(STAT, d); check("R5 cmp1 flag before", d[2], 0);
        check("R5 pin1 before", cmp_out[0], 0);
        @(negedge clk);
        rd(STAT, d); check("R5 cmp1 flag after", d[2], 1);
        check("R5 pin1 after", cmp_out[0], 1);

        // R5 compare 2 with irq
        wr(CTRL, 8'h43);
        tgt = exp_cnt + 10'd40;
        wr16(CM2L, 16'(tgt));
        wr(STAT, 8'h1F);
        while (exp_cnt != tgt) @(negedge clk);
        check("R5 pin2 before", cmp_out[1], 0);
        check("R9 irq before match", irq, 0);
        @(negedge clk);
        check("R5 pin2 after", cmp_out[1], 1);
        check("R9 compare irq", irq, 1);
        wr(STAT, 8'h0C);
        check("R8 cmp clear", irq, 0);

        // R5 enables clear gate the pins
        wr(MODE, 8'h00);
        check("R5 pins gated", cmp_out, 0);

        // R6 force ignored while disabled, then applied
        wr(CTRL, 8'h08);
        wr(MODE, 8'h01);
        check("R6 force ignored", cmp_out[0], 1);
        wr(CTRL, 8'h08);
        check("R6 force low", cmp_out[0], 0);
        wr(CTRL, 8'h09);
        check("R6 force high", cmp_out[0], 1);
        rd(CTRL, d); check("R6 force reads zero", d, 8'h01);
        wr(MODE, 8'h03);
        wr(CTRL, 8'h10);
        check("R6 force pin2 low", cmp_out[1], 0);

        // R7 pulse mode uses level 2 for pin 1
        wr(MODE, 8'h05);
        wr(CTRL, 8'h09);
        check("R7 pulse level2 low", cmp_out[0], 0);
        wr(CTRL, 8'h0A);
        check("R7 pulse level2 high", cmp_out[0], 1);

        // R2 overflow, R8, R9
        wr(MODE, 8'h00);
        wr(CTRL, 8'h80);
        wr(STAT, 8'h1F);
        while (exp_cnt != TOP) @(negedge clk);
        rd(STAT, d); check("R2 ovf before wrap", d[4], 0);
        check("R9 irq before wrap", irq, 0);
        @(negedge clk);
        rd(STAT, d); check("R2 ovf after wrap", d[4], 1);
        rd16(CNTL, v); check("R1 wrap to zero", v, 0);
        check("R9 overflow irq", irq, 1);
        wr(STAT, 8'h00);
        rd(STAT, d); check("R8 zero write keeps flag", d[4], 1);
        wr(CTRL, 8'h00);
        check("R9 enable off", irq, 0);
        wr(CTRL, 8'h80);
        check("R9 enable on", irq, 1);
        wr(STAT, 8'h10);
        rd(STAT, d); check("R8 ovf cleared", d[4], 0);
        check("R9 irq after clear", irq, 0);

        finish_run();
    end
endmodule